// File: doc/BRIEF.md
# Board configuration command controller

This block gives software a small command window on the register bus for board-level configuration transactions. It holds three registers: a 32-bit argument register, a command register and a two-bit completion status register. A write to the command register acts in the same cycle. The stored command word has two reserved bits forced low. The status register is set to "done". Two exact command words are turned into one-cycle request pulses: one asks the system to power down and the other asks it to restart. Every other command word also raises the error flag in the status register.

The window is live only when the board identifier input equals one configured value. For any other identifier, the three offsets behave as undefined locations. Reads return zero, writes change nothing, and an access-error strobe marks the access. The bus is a plain single-cycle register port. Writes take effect at the clock edge on which `wr_en` is high. Read data is combinational from the address. There is no stream traffic, so no valid/ready handshake is used, and the bus never stalls.

Top module: `brdcfg_cmd_ctrl`

## Requirements
- R1: After reset, the argument, command and status registers all read 0, and `shutdown_req` and `reboot_req` are low.
- R2: With the window enabled, the argument register at offset 0xA0 stores and returns all 32 bits of any written value.
- R3: A write to the command register at offset 0xA4 stores the written word with bits 19 and 18 cleared. Reads of offset 0xA4 never show those bits set.
- R4: Every enabled write to the command register sets status bit 0 (done). The new status is visible from the cycle after the write.
- R5: When the stored command word equals 0xC0800000, `shutdown_req` is high for exactly the one cycle after the write, and status reads 1.
- R6: When the stored command word equals 0xC0900000, `reboot_req` is high for exactly the one cycle after the write, and status reads 1. Because of R3, a written 0xC09C0000 also counts as a restart.
- R7: For any other stored command word, status reads 3: bit 1 is the error flag and bit 0 is done. Neither request pulse occurs.
- R8: A write to the status register at offset 0xA8 stores only bits 1:0 of the written value. Bits 31:2 always read 0.
- R9: When `board_id` is not 0x190, reads of 0xA0, 0xA4 and 0xA8 return 0. Writes to those offsets leave all registers unchanged and produce no pulse. `acc_err` is high during any such access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| board_id | input | 12 | Board identifier; the window is live only for 0x190 |
| wr_en | input | 1 | Write strobe for the current address |
| rd_en | input | 1 | Read strobe for the current address |
| addr | input | 8 | Byte offset within the register page |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational; 0 when the address is not a live register |
| acc_err | output | 1 | High during an access to the window while it is disabled |
| shutdown_req | output | 1 | One-cycle power-down request |
| reboot_req | output | 1 | One-cycle restart request |

## Verification
On every cycle, the assertions check four things. Each request pulse is traced back to an enabled command write of the matching masked word in the previous cycle. The two pulses never coincide. A command read never shows the reserved bits. A disabled window always reads zero. The assertions also check that the done flag is set after each enabled command write. Only the bench scenarios can show that stored values round-trip through the data path. Those scenarios also cover the exact status codes 1, 3 and the truncated status write, and the one-cycle width of each pulse. Finally, they show that writes made while the window is disabled leave no trace once it is enabled again.

// File: rtl/brdcfg_pkg.sv
package brdcfg_pkg;
  typedef enum logic [1:0] {
    CMD_OTHER  = 2'd0,
    CMD_SHUT   = 2'd1,
    CMD_REBOOT = 2'd2
  } cmd_kind_e;

  localparam int STAT_W    = 2;
  localparam int STAT_DONE = 0;
  localparam int STAT_ERR  = 1;
endpackage

// File: rtl/brdcfg_decode.sv
module brdcfg_decode #(
  parameter int               ADDR_W    = 8,
  parameter int               ID_W      = 12,
  parameter logic [ID_W-1:0]  LIVE_ID   = 12'h190,
  parameter logic [ADDR_W-1:0] OFF_ARG  = 8'hA0,
  parameter logic [ADDR_W-1:0] OFF_CMD  = 8'hA4,
  parameter logic [ADDR_W-1:0] OFF_STAT = 8'hA8
) (
  input  logic [ID_W-1:0]   board_id,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic              live,
  output logic [2:0]        sel,
  output logic [2:0]        wstb,
  output logic              acc_err
);
  localparam int NREG = 3;
  logic [NREG-1:0][ADDR_W-1:0] offs;
  assign offs = {OFF_STAT, OFF_CMD, OFF_ARG};

  assign live = (board_id == LIVE_ID);

  for (genvar i = 0; i < NREG; i++) begin : g_match
    assign sel[i]  = (addr == offs[i]);
    assign wstb[i] = sel[i] & wr_en & live;
  end

  assign acc_err = (rd_en | wr_en) & (|sel) & ~live;
endmodule

// File: rtl/brdcfg_cmd.sv
module brdcfg_cmd
  import brdcfg_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] RSVD_MASK = 32'h000C_0000,
  parameter logic [DATA_W-1:0] CMD_SHUT_W = 32'hC080_0000,
  parameter logic [DATA_W-1:0] CMD_BOOT_W = 32'hC090_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cmd_word,
  output cmd_kind_e         kind,
  output logic              shutdown_req,
  output logic              reboot_req
);
  assign cmd_word = wdata & ~RSVD_MASK;

  always_comb begin
    if (cmd_word == CMD_SHUT_W)      kind = CMD_SHUT;
    else if (cmd_word == CMD_BOOT_W) kind = CMD_REBOOT;
    else                             kind = CMD_OTHER;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shutdown_req <= 1'b0;
      reboot_req   <= 1'b0;
    end else begin
      shutdown_req <= cmd_wr && (kind == CMD_SHUT);
      reboot_req   <= cmd_wr && (kind == CMD_REBOOT);
    end
  end
endmodule

// File: rtl/brdcfg_regs.sv
module brdcfg_regs
  import brdcfg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        wstb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] cmd_word,
  input  cmd_kind_e         kind,
  output logic [DATA_W-1:0] arg_q,
  output logic [DATA_W-1:0] cmd_q,
  output logic [STAT_W-1:0] stat_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arg_q  <= '0;
      cmd_q  <= '0;
      stat_q <= '0;
    end else begin
      if (wstb[0]) arg_q <= wdata;
      if (wstb[1]) begin
        cmd_q            <= cmd_word;
        stat_q[STAT_DONE] <= 1'b1;
        stat_q[STAT_ERR]  <= (kind == CMD_OTHER);
      end else if (wstb[2]) begin
        stat_q <= wdata[STAT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/brdcfg_cmd_ctrl.sv
module brdcfg_cmd_ctrl
  import brdcfg_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter int                ADDR_W    = 8,
  parameter int                ID_W      = 12,
  parameter logic [ID_W-1:0]   LIVE_ID   = 12'h190,
  parameter logic [DATA_W-1:0] RSVD_MASK = 32'h000C_0000,
  parameter logic [DATA_W-1:0] CMD_SHUT_W = 32'hC080_0000,
  parameter logic [DATA_W-1:0] CMD_BOOT_W = 32'hC090_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   board_id,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              acc_err,
  output logic              shutdown_req,
  output logic              reboot_req
);
  logic              live;
  logic [2:0]        sel;
  logic [2:0]        wstb;
  logic [DATA_W-1:0] cmd_word;
  cmd_kind_e         kind;
  logic [DATA_W-1:0] arg_q;
  logic [DATA_W-1:0] cmd_q;
  logic [STAT_W-1:0] stat_q;

  brdcfg_decode #(
    .ADDR_W(ADDR_W), .ID_W(ID_W), .LIVE_ID(LIVE_ID)
  ) u_dec (
    .board_id(board_id), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .live(live), .sel(sel), .wstb(wstb), .acc_err(acc_err)
  );

  brdcfg_cmd #(
    .DATA_W(DATA_W), .RSVD_MASK(RSVD_MASK),
    .CMD_SHUT_W(CMD_SHUT_W), .CMD_BOOT_W(CMD_BOOT_W)
  ) u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_wr(wstb[1]), .wdata(wdata),
    .cmd_word(cmd_word), .kind(kind),
    .shutdown_req(shutdown_req), .reboot_req(reboot_req)
  );

  brdcfg_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wstb(wstb), .wdata(wdata),
    .cmd_word(cmd_word), .kind(kind),
    .arg_q(arg_q), .cmd_q(cmd_q), .stat_q(stat_q)
  );

  always_comb begin
    rdata = '0;
    if (live) begin
      if (sel[0])      rdata = arg_q;
      else if (sel[1]) rdata = cmd_q;
      else if (sel[2]) rdata = {{(DATA_W-STAT_W){1'b0}}, stat_q};
    end
  end
endmodule

// File: rtl/brdcfg_chk.sv
module brdcfg_chk #(
  parameter int                DATA_W    = 32,
  parameter int                ADDR_W    = 8,
  parameter logic [DATA_W-1:0] RSVD_MASK = 32'h000C_0000,
  parameter logic [DATA_W-1:0] CMD_SHUT_W = 32'hC080_0000,
  parameter logic [DATA_W-1:0] CMD_BOOT_W = 32'hC090_0000,
  parameter logic [ADDR_W-1:0] OFF_ARG  = 8'hA0,
  parameter logic [ADDR_W-1:0] OFF_CMD  = 8'hA4,
  parameter logic [ADDR_W-1:0] OFF_STAT = 8'hA8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              live,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              shutdown_req,
  input logic              reboot_req,
  input logic [1:0]        stat_q
);
  logic cmd_wr_live;
  logic in_win;
  assign cmd_wr_live = wr_en && live && (addr == OFF_CMD);
  assign in_win = (addr == OFF_ARG) || (addr == OFF_CMD) || (addr == OFF_STAT);

  AST_SHUT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> $past(cmd_wr_live && ((wdata & ~RSVD_MASK) == CMD_SHUT_W))); // R5
  AST_BOOT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_req |-> $past(cmd_wr_live && ((wdata & ~RSVD_MASK) == CMD_BOOT_W))); // R6
  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(shutdown_req && reboot_req)); // R7
  AST_RSVD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && live && addr == OFF_CMD) |-> ((rdata & RSVD_MASK) == '0)); // R3
  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_live |=> stat_q[0]); // R4
  AST_DARK_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !live && in_win) |-> (rdata == '0)); // R9
endmodule

bind brdcfg_cmd_ctrl brdcfg_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RSVD_MASK(RSVD_MASK),
  .CMD_SHUT_W(CMD_SHUT_W), .CMD_BOOT_W(CMD_BOOT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .live(live), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wdata(wdata), .rdata(rdata),
  .shutdown_req(shutdown_req), .reboot_req(reboot_req), .stat_q(stat_q)
);

// File: tb/brdcfg_cmd_ctrl_tb.sv
module brdcfg_cmd_ctrl_tb;
  localparam logic [7:0] A_ARG = 8'hA0, A_CMD = 8'hA4, A_STAT = 8'hA8;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [11:0] board_id = 12'h190;
  logic        wr_en = 0, rd_en = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        acc_err, shutdown_req, reboot_req;

  int errors = 0, checks = 0;
  logic p_shut, p_boot, q_shut, q_boot;
  logic [31:0] rv;
  logic        rv_err;

  always #2 clk = ~clk;

  brdcfg_cmd_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .board_id(board_id), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .acc_err(acc_err),
    .shutdown_req(shutdown_req), .reboot_req(reboot_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // p_* = pulses in the cycle after the write, q_* = one cycle later
  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
    p_shut = shutdown_req; p_boot = reboot_req;
    @(negedge clk);
    q_shut = shutdown_req; q_boot = reboot_req;
  endtask

  task automatic bus_rd(input logic [7:0] a);
    @(negedge clk);
    rd_en = 1; addr = a;
    #1;
    rv = rdata; rv_err = acc_err;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic t_reset();
    bus_rd(A_ARG);  chk("R1 arg reset", rv, 0);
    bus_rd(A_CMD);  chk("R1 cmd reset", rv, 0);
    bus_rd(A_STAT); chk("R1 stat reset", rv, 0);
    chk("R1 pulses low", {30'd0, shutdown_req, reboot_req}, 0);
  endtask

  task automatic t_arg();
    bus_wr(A_ARG, 32'hDEAD_BEEF); bus_rd(A_ARG); chk("R2 arg pattern a", rv, 32'hDEAD_BEEF);
    bus_wr(A_ARG, 32'hFFFF_FFFF); bus_rd(A_ARG); chk("R2 arg all ones", rv, 32'hFFFF_FFFF);
    bus_wr(A_ARG, 32'h0000_0001); bus_rd(A_ARG); chk("R2 arg pattern b", rv, 32'h0000_0001);
  endtask

  task automatic t_other();
    bus_wr(A_STAT, 0);
    bus_wr(A_CMD, 32'hFFFF_FFFF);
    chk("R7 no pulse", {30'd0, p_shut, p_boot}, 0);
    bus_rd(A_CMD);  chk("R3 reserved bits cleared", rv, 32'hFFF3_FFFF);
    bus_rd(A_STAT); chk("R7 status error", rv, 3);
    chk("R4 done bit", {31'd0, rv[0]}, 1);
  endtask

  task automatic t_shut();
    bus_wr(A_STAT, 0);
    bus_wr(A_CMD, 32'hC080_0000);
    chk("R5 shutdown pulse", {30'd0, p_shut, p_boot}, 32'h2);
    chk("R5 pulse one cycle", {30'd0, q_shut, q_boot}, 0);
    bus_rd(A_STAT); chk("R5 status done", rv, 1);
  endtask

  task automatic t_boot();
    bus_wr(A_CMD, 32'hC090_0000);
    chk("R6 reboot pulse", {30'd0, p_shut, p_boot}, 32'h1);
    chk("R6 pulse one cycle", {30'd0, q_shut, q_boot}, 0);
    bus_rd(A_STAT); chk("R6 status done", rv, 1);
    bus_wr(A_CMD, 32'hC09C_0000);
    chk("R6 masked word reboots", {30'd0, p_shut, p_boot}, 32'h1);
    bus_rd(A_CMD); chk("R3 masked word stored", rv, 32'hC090_0000);
    bus_wr(A_CMD, 32'hC080_0001);
    chk("R7 near miss no pulse", {30'd0, p_shut, p_boot}, 0);
    bus_rd(A_STAT); chk("R7 near miss error", rv, 3);
  endtask

  task automatic t_stat();
    bus_wr(A_STAT, 32'hFFFF_FFFE); bus_rd(A_STAT); chk("R8 status low bits", rv, 2);
    bus_wr(A_STAT, 32'h8000_0001); bus_rd(A_STAT); chk("R8 status truncated", rv, 1);
  endtask

  task automatic t_dark();
    bus_wr(A_ARG, 32'h1111_1111);
    bus_wr(A_STAT, 32'h2);
    board_id = 12'h182;
    bus_wr(A_ARG, 32'h2222_2222);
    bus_wr(A_CMD, 32'hC080_0000);
    chk("R9 no pulse when disabled", {30'd0, p_shut, p_boot}, 0);
    bus_wr(A_STAT, 32'h1);
    bus_rd(A_ARG);  chk("R9 dark read zero", rv, 0);
    chk("R9 acc_err on read", {31'd0, rv_err}, 1);
    bus_rd(A_STAT); chk("R9 dark status zero", rv, 0);
    board_id = 12'h190;
    bus_rd(A_ARG);  chk("R9 arg unchanged", rv, 32'h1111_1111);
    chk("R9 no acc_err when live", {31'd0, rv_err}, 0);
    bus_rd(A_STAT); chk("R9 status unchanged", rv, 2);
    bus_rd(A_CMD);  chk("R9 cmd unchanged", rv, 32'hC080_0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_arg();
    t_other();
    t_shut();
    t_boot();
    t_stat();
    t_dark();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule